// File: doc/BRIEF.md
# Host-target mailbox console

This peripheral is a pair of 64-bit mailbox registers through which a processor and a host exchange commands and replies. The processor writes a command into the outbound mailbox and collects the reply from the inbound mailbox. Each mailbox is reached as two 32-bit words on a simple register bus. The bus has a write strobe, a word address, write data, and read data that follows the address combinationally.

When both halves of a command have been written, the block decodes the command one cycle later. A system command carries a test exit code, which the block reports with a one-cycle pulse. A console "put" command sends a byte on a valid/ready output stream. A console "get" command records a pending read. That read is completed when a character arrives on a valid/ready input stream.

Every completed command loads the inbound mailbox with the command's device and command bytes above a 48-bit response. It then empties the outbound mailbox. A reply is never written over an occupied inbound mailbox.

Top module: `hostlink_mbox`

## Requirements
- R1: Reset is synchronous and active high. After reset, all four mailbox words read 0, `tx_valid`, `rx_ready` and `exit_pulse` are 0, and the accept and in-progress flags and the pending read are cleared.
- R2: Byte address `OUT_BASE` (default 0) reads outbound bits 31:0, and `OUT_BASE+4` reads bits 63:32. `IN_BASE` (default 8) and `IN_BASE+4` read the inbound halves in the same way. Any other address reads 0, and a write to any other address changes nothing.
- R3: A write to the outbound low word is accepted only while the outbound mailbox is zero and no command is being decoded. An accepted write loads the word zero-extended and arms an accept flag. A rejected write leaves the mailbox unchanged and disarms the flag.
- R4: A write to the outbound high word takes effect only while the accept flag is armed. It ORs the data into bits 63:32, disarms the flag, and starts decode. With the flag disarmed, the write is ignored.
- R5: The command word holds the device in bits 63:56, the command in bits 55:48 and the payload in bits 47:0. Device 0, command 0 with payload bit 0 set gives a one-cycle `exit_pulse` with `exit_code` = payload[47:1] and a zero response.
- R6: Device 0, command 0 with payload bit 0 clear is unsupported. It gives no exit pulse and completes with a zero response.
- R7: Device 1, command 1 presents payload[7:0] on `tx_data` with `tx_valid`, held steady until `tx_ready`. The command completes in the handshake cycle with response 0x100 | byte. Until then, the outbound mailbox keeps the command.
- R8: Completion of any command other than device 1, command 0 loads the inbound mailbox with {command[63:48], response[47:0]} and clears the outbound mailbox. This happens one cycle after the high-word write, or later: the load waits while the inbound mailbox is nonzero or its in-progress flag is set.
- R9: Device 1, command 0 saves command bits 63:48 as a pending read, clears the outbound mailbox and leaves the inbound mailbox unchanged.
- R10: `rx_ready` is high only while a read is pending, the inbound mailbox is zero, its in-progress flag is clear and no command is being decoded. An accepted character loads the inbound mailbox with {pending bits 63:48, 0x100 | character} and clears the pending read.
- R11: Unknown device or command codes complete with a zero response.
- R12: A write to the inbound low word loads the word zero-extended into the mailbox and sets the in-progress flag. A write to the inbound high word ORs the data into bits 63:32 and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of a 32-bit word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tx_valid | output | 1 | Output byte available |
| tx_ready | input | 1 | Sink takes the byte |
| tx_data | output | 8 | Output byte |
| rx_valid | input | 1 | Input character available |
| rx_ready | output | 1 | Block takes the character |
| rx_data | input | 8 | Input character |
| exit_pulse | output | 1 | One-cycle exit report |
| exit_code | output | 47 | Exit code, held until the next report |

## Verification
Corrupted state shows up as the wrong value at the ports, and mostly within a cycle or two:

- A wrong accept flag shows at once in the next outbound read: a rejected low word appears there, or an ignored high word lands in bits 63:32.
- A wrong decode shows one cycle after the high-word write, as the wrong header in the inbound mailbox or a stray exit pulse or output byte.
- A lost in-progress flag or a bad stall shows as a reply that appears while the inbound mailbox is still occupied or half-written.
- A stale pending read shows as `rx_ready` rising when no read is pending.
- A dropped hold under backpressure shows as `tx_data` changing, or `tx_valid` falling, before `tx_ready`.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
    localparam int WORD_W    = 32;
    localparam int REG_W     = 2 * WORD_W;
    localparam int FIELD_W   = 8;
    localparam int HDR_W     = 2 * FIELD_W;
    localparam int PAYLOAD_W = REG_W - HDR_W;
    localparam int CODE_W    = PAYLOAD_W - 1;
    localparam int CHAR_W    = 8;
    localparam int HI_OFS    = WORD_W / 8;

    localparam logic [FIELD_W-1:0] DEV_SYS  = 8'd0;
    localparam logic [FIELD_W-1:0] DEV_CON  = 8'd1;
    localparam logic [FIELD_W-1:0] OP_EXIT  = 8'd0;
    localparam logic [FIELD_W-1:0] OP_GET   = 8'd0;
    localparam logic [FIELD_W-1:0] OP_PUT   = 8'd1;
    localparam logic [PAYLOAD_W-1:0] CHAR_ACK = PAYLOAD_W'(12'h100);

    typedef enum logic [2:0] {
        K_EXIT,
        K_NOEXIT,
        K_PUT,
        K_GET,
        K_UNKNOWN
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [HDR_W-1:0]  hdr;
        logic [CODE_W-1:0] code;
        logic [CHAR_W-1:0] ch;
    } dec_t;

    typedef struct packed {
        logic [REG_W-1:0]  outr;
        logic [REG_W-1:0]  inr;
        logic [HDR_W-1:0]  pend_hdr;
        logic              pend_vld;
        logic              allow;
        logic              inprog;
        logic              busy;
        logic              sending;
        logic              exit_p;
        logic [CODE_W-1:0] exit_code;
    } state_t;
endpackage

// File: rtl/hostlink_decode.sv
module hostlink_decode
    import hostlink_pkg::*;
(
    input  logic [REG_W-1:0] cmd,
    output dec_t             dec
);
    logic [FIELD_W-1:0]   dev;
    logic [FIELD_W-1:0]   op;
    logic [PAYLOAD_W-1:0] payload;

    assign dev     = cmd[REG_W-1 -: FIELD_W];
    assign op      = cmd[PAYLOAD_W +: FIELD_W];
    assign payload = cmd[PAYLOAD_W-1:0];

    always_comb begin
        dec.hdr  = cmd[REG_W-1 -: HDR_W];
        dec.code = payload[PAYLOAD_W-1:1];
        dec.ch   = payload[CHAR_W-1:0];
        dec.kind = K_UNKNOWN;
        if (dev == DEV_SYS) begin
            if (op == OP_EXIT) dec.kind = payload[0] ? K_EXIT : K_NOEXIT;
        end else if (dev == DEV_CON) begin
            if (op == OP_PUT)      dec.kind = K_PUT;
            else if (op == OP_GET) dec.kind = K_GET;
        end
    end
endmodule

// File: rtl/hostlink_rdmux.sv
module hostlink_rdmux
    import hostlink_pkg::*;
#(
    parameter int               ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] OUT_BASE = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] IN_BASE  = ADDR_W'(8)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  outr,
    input  logic [REG_W-1:0]  inr,
    output logic [WORD_W-1:0] rdata
);
    localparam int NREG = 2;

    logic [REG_W-1:0]  regs  [NREG];
    logic [ADDR_W-1:0] bases [NREG];
    logic [WORD_W-1:0] hit   [NREG];

    assign regs[0]  = outr;
    assign regs[1]  = inr;
    assign bases[0] = OUT_BASE;
    assign bases[1] = IN_BASE;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            if (addr == bases[g])
                hit[g] = regs[g][WORD_W-1:0];
            else if (addr == bases[g] + ADDR_W'(HI_OFS))
                hit[g] = regs[g][REG_W-1:WORD_W];
            else
                hit[g] = '0;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) rdata = rdata | hit[i];
    end
endmodule

// File: rtl/hostlink_mbox.sv
module hostlink_mbox
    import hostlink_pkg::*;
#(
    parameter int               ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] OUT_BASE = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] IN_BASE  = ADDR_W'(8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              exit_pulse,
    output logic [CODE_W-1:0] exit_code
);
    state_t q, d;
    dec_t   dec;

    logic wr_out_lo, wr_out_hi, wr_in_lo, wr_in_hi;
    logic in_free, fin;
    logic [PAYLOAD_W-1:0] resp;

    assign wr_out_lo = bus_wr && (bus_addr == OUT_BASE);
    assign wr_out_hi = bus_wr && (bus_addr == OUT_BASE + ADDR_W'(HI_OFS));
    assign wr_in_lo  = bus_wr && (bus_addr == IN_BASE);
    assign wr_in_hi  = bus_wr && (bus_addr == IN_BASE + ADDR_W'(HI_OFS));

    hostlink_decode u_dec (
        .cmd (q.outr),
        .dec (dec)
    );

    hostlink_rdmux #(
        .ADDR_W   (ADDR_W),
        .OUT_BASE (OUT_BASE),
        .IN_BASE  (IN_BASE)
    ) u_rd (
        .addr  (bus_addr),
        .outr  (q.outr),
        .inr   (q.inr),
        .rdata (bus_rdata)
    );

    assign in_free    = (q.inr == '0) && !q.inprog;
    assign tx_valid   = q.busy && (dec.kind == K_PUT) && (in_free || q.sending);
    assign tx_data    = dec.ch;
    assign rx_ready   = q.pend_vld && in_free && !q.busy;
    assign exit_pulse = q.exit_p;
    assign exit_code  = q.exit_code;

    always_comb begin
        d        = q;
        d.exit_p = 1'b0;
        fin      = 1'b0;
        resp     = '0;

        // outbound mailbox, written by the target
        if (wr_out_lo) begin
            if (q.outr == '0 && !q.busy) begin
                d.outr  = {{WORD_W{1'b0}}, bus_wdata};
                d.allow = 1'b1;
            end else begin
                d.allow = 1'b0;
            end
        end
        if (wr_out_hi && q.allow) begin
            d.outr  = q.outr | {bus_wdata, {WORD_W{1'b0}}};
            d.allow = 1'b0;
            d.busy  = 1'b1;
        end

        // inbound mailbox, acknowledged by the target
        if (wr_in_lo) begin
            d.inr    = {{WORD_W{1'b0}}, bus_wdata};
            d.inprog = 1'b1;
        end
        if (wr_in_hi) begin
            d.inr    = q.inr | {bus_wdata, {WORD_W{1'b0}}};
            d.inprog = 1'b0;
        end

        // command decode and completion
        if (q.busy) begin
            case (dec.kind)
                K_GET: begin
                    d.pend_hdr = dec.hdr;
                    d.pend_vld = 1'b1;
                    d.outr     = '0;
                    d.busy     = 1'b0;
                end
                K_PUT: begin
                    d.sending = tx_valid && !tx_ready;
                    if (tx_valid && tx_ready) begin
                        fin  = 1'b1;
                        resp = CHAR_ACK | PAYLOAD_W'(dec.ch);
                    end
                end
                K_EXIT: begin
                    if (in_free) begin
                        fin         = 1'b1;
                        d.exit_p    = 1'b1;
                        d.exit_code = dec.code;
                    end
                end
                default: fin = in_free;
            endcase
        end
        if (fin) begin
            d.inr     = {dec.hdr, resp};
            d.inprog  = 1'b0;
            d.outr    = '0;
            d.busy    = 1'b0;
            d.sending = 1'b0;
        end

        // console input completes a pending read
        if (rx_valid && rx_ready) begin
            d.inr      = {q.pend_hdr, CHAR_ACK | PAYLOAD_W'(rx_data)};
            d.inprog   = 1'b0;
            d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R1: registers empty after reset
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (q.outr == '0 && q.inr == '0 && !tx_valid && !rx_ready && !exit_pulse));

    // R3: a nonzero idle outbound mailbox is not overwritten by a low-word write
    p_lo_reject_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_out_lo && q.outr != '0 && !q.busy) |=> (q.outr == $past(q.outr)));

    // R5: exit report lasts one cycle
    p_exit_onecycle_r5: assert property (@(posedge clk) disable iff (rst)
        exit_pulse |=> !exit_pulse);

    // R7: output byte held until taken
    p_tx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R8: no reply over an occupied inbound mailbox
    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (q.busy && dec.kind != K_GET && !q.sending && !in_free) |=> q.busy);

    // R10: accepted character lands in the response field
    p_rx_load_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready) |=> (q.inr[PAYLOAD_W-1:0] == (CHAR_ACK | PAYLOAD_W'($past(rx_data)))));
endmodule

// File: tb/tb_hostlink_mbox.sv
module tb_hostlink_mbox;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_OLO = 5'd0, A_OHI = 5'd4, A_ILO = 5'd8, A_IHI = 5'd12, A_BAD = 5'd16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0;
    logic        exit_pulse;
    logic [46:0] exit_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0]  exp_tx   [$];
    logic [46:0] exp_exit [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hostlink_mbox dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .exit_pulse(exit_pulse), .exit_code(exit_code)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); bus_addr = a; #1;
        chk(64'(bus_rdata), 64'(exp), tag);
    endtask

    task automatic send(input logic [63:0] c);
        wr(A_OLO, c[31:0]);
        wr(A_OHI, c[63:32]);
    endtask

    task automatic clear_in();
        wr(A_ILO, 32'h0);
        wr(A_IHI, 32'h0);
    endtask

    // scoreboard monitor: sample between edges
    always @(negedge clk) begin
        #2;
        if (!rst && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) chk(64'(tx_data), 64'hx, "R7 unexpected tx byte");
            else chk(64'(tx_data), 64'(exp_tx.pop_front()), "R7 tx byte");
        end
        if (!rst && exit_pulse) begin
            if (exp_exit.size() == 0) chk(64'(exit_code), 64'hx, "R5/R6 unexpected exit pulse");
            else chk(64'(exit_code), 64'(exp_exit.pop_front()), "R5 exit code");
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        rd_chk(A_OLO, 0, "R1 out lo"); rd_chk(A_OHI, 0, "R1 out hi");
        rd_chk(A_ILO, 0, "R1 in lo");  rd_chk(A_IHI, 0, "R1 in hi");
        chk({tx_valid, rx_ready, exit_pulse}, 0, "R1 outputs idle");

        // R4 high write without an armed flag is ignored
        wr(A_OHI, 32'h0101_0000);
        rd_chk(A_OHI, 0, "R4 unarmed high ignored");
        chk(64'(tx_valid), 0, "R4 no decode");

        // R2 / R3 word access, unmapped, rejection
        wr(A_OLO, 32'hAABB_CCDD);
        rd_chk(A_OLO, 32'hAABB_CCDD, "R2 out lo read");
        rd_chk(A_OHI, 0, "R2 out hi read");
        wr(A_BAD, 32'hFFFF_FFFF);
        rd_chk(A_BAD, 0, "R2 unmapped read");
        rd_chk(A_OLO, 32'hAABB_CCDD, "R2 unmapped write ignored");
        wr(A_OLO, 32'h1111_1111);
        rd_chk(A_OLO, 32'hAABB_CCDD, "R3 nonzero low rejected");
        wr(A_OHI, 32'h2222_2222);
        rd_chk(A_OHI, 0, "R3 disarmed high ignored");

        do_reset();
        // R5 exit
        exp_exit.push_back(47'h12_3456_789A);
        send({8'h00, 8'h00, 47'h12_3456_789A, 1'b1});
        rd_chk(A_OLO, 0, "R5 outbound cleared");
        rd_chk(A_IHI, 0, "R5 zero reply header");
        repeat (2) @(negedge clk);
        chk(64'(exp_exit.size()), 0, "R5 exit reported");

        // R6 unsupported system command: no pulse, zero reply
        send({8'h00, 8'h00, 48'h0000_0000_0ABC});
        rd_chk(A_OHI, 0, "R6 outbound cleared");
        rd_chk(A_ILO, 0, "R6 zero response");

        // R11 unknown device
        send({8'h37, 8'h05, 48'h0000_0000_0ABC});
        rd_chk(A_IHI, 32'h3705_0000, "R11 header echoed");
        rd_chk(A_ILO, 0, "R11 zero response");

        // R8 stall on occupied inbound, R12 in-progress
        tx_ready = 1'b1;
        exp_tx.push_back(8'h41);
        send({8'h01, 8'h01, 48'h41});
        repeat (2) @(negedge clk); #1;
        chk(64'(tx_valid), 0, "R8 stalled while inbound nonzero");
        wr(A_ILO, 32'h0); #1;
        chk(64'(tx_valid), 0, "R12 stalled while in progress");
        rd_chk(A_OHI, 32'h0101_0000, "R8 outbound kept while stalled");
        wr(A_IHI, 32'h0);
        @(negedge clk);
        rd_chk(A_IHI, 32'h0101_0000, "R8 put reply header");
        rd_chk(A_ILO, 32'h0000_0141, "R7 put response");
        rd_chk(A_OLO, 0, "R8 outbound cleared after put");

        // R7 backpressure
        clear_in();
        tx_ready = 1'b0;
        exp_tx.push_back(8'h5A);
        send({8'h01, 8'h01, 48'h7700_0000_005A});
        repeat (3) @(negedge clk); #1;
        chk({tx_valid, tx_data}, {1'b1, 8'h5A}, "R7 byte held");
        rd_chk(A_OLO, 32'h0000_005A, "R7 outbound kept");
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        rd_chk(A_ILO, 32'h0000_015A, "R7 reply after handshake");
        chk(64'(exp_tx.size()), 0, "R7 all bytes sent");
        tx_ready = 1'b1;

        // R12 inbound word writes
        wr(A_ILO, 32'hDEAD_BEEF);
        rd_chk(A_IHI, 0, "R12 low write zero-extends");
        wr(A_IHI, 32'h00C0_FFEE);
        rd_chk(A_IHI, 32'h00C0_FFEE, "R12 high write ORs");
        rd_chk(A_ILO, 32'hDEAD_BEEF, "R12 low kept");

        // R9 / R10 pending console read
        send({8'h01, 8'h00, 48'h777});
        rd_chk(A_OLO, 0, "R9 outbound cleared");
        rd_chk(A_ILO, 32'hDEAD_BEEF, "R9 inbound unchanged");
        #1; chk(64'(rx_ready), 0, "R10 not ready while inbound busy");
        clear_in(); #1;
        chk(64'(rx_ready), 1, "R10 ready when pending and free");
        @(negedge clk); rx_data = 8'h4B; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        rd_chk(A_IHI, 32'h0100_0000, "R10 pending header");
        rd_chk(A_ILO, 32'h0000_014B, "R10 char response");
        clear_in(); #1;
        chk(64'(rx_ready), 0, "R10 pending cleared after serve");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule